// File: doc/BRIEF.md
# Supply Supervisor with Bus-Start Watchdog

This block sequences a system reset and a second-rail failure flag from three comparator decisions that are already digital. The decisions are: the supply is above its minimum valid level, the supply is above the primary trip level, and the second rail is above its own trip level. The system reset is held low while the supply is invalid or below the primary trip. After the supply recovers, the reset stays low until the supply has been good for a programmable number of clock cycles. The failure flag follows the second rail with no release delay.

A watchdog runs only while the reset is released and the watchdog is enabled. Each start condition seen on a two-wire serial bus restarts it: the data line falls while the clock line is high. If no start arrives within the timeout, the block drives a reset pulse of fixed length. When the supply turns bad, a one-cycle abort strobe tells the serial interface to drop the command it is handling. All time constants are parameters counted in clock cycles. Both outputs are active low, so a pad can use them as drive-low or release.

Top module: `rail_supervisor`

## Requirements
- R1: One clock edge after the supply is sampled invalid (`vmin_ok_i`=0) or below the primary trip (`pri_ok_i`=0), `sys_rst_n_o` is 0.
- R2: When both supply inputs have been 1 on PU_DLY consecutive clock edges, `sys_rst_n_o` is still 0. On the next edge it goes to 1, unless a watchdog pulse is active.
- R3: A supply dip during the release delay clears the delay. The full PU_DLY count starts again from the first good edge after the dip.
- R4: One edge after it is sampled, `sec_fail_n_o` equals `sec_ok_i` AND `vmin_ok_i`. Recovery of the second rail releases the flag on that edge, with no added delay.
- R5: `bus_abort_o` is 1 for exactly one cycle, following the first edge at which the supply turns bad after being good. It is 0 at all other times, including during a watchdog reset.
- R6: With `wdog_en_i`=1 and no start condition, the counter runs for WD_TMO edges after the counting starts. `sys_rst_n_o` then goes to 0 on the next edge and stays 0 for exactly RST_PULSE cycles.
- R7: A start condition (`sda_i` falling while `scl_i` is 1, seen through a two-stage synchronizer) restarts the watchdog count. Data edges while `scl_i` is 0 do not. A start that arrives in the same cycle as an expiry cancels the expiry.
- R8: The watchdog count is held at zero while `sys_rst_n_o` is 0 or `wdog_en_i` is 0. Counting begins on the edge after release.
- R9: While `rst` is 1, `sys_rst_n_o`=0, `sec_fail_n_o`=0 and `bus_abort_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vmin_ok_i | input | 1 | Supply above minimum valid level |
| pri_ok_i | input | 1 | Supply above primary trip level |
| sec_ok_i | input | 1 | Second rail above its trip level |
| wdog_en_i | input | 1 | Watchdog enable |
| scl_i | input | 1 | Serial bus clock line (asynchronous) |
| sda_i | input | 1 | Serial bus data line (asynchronous) |
| sys_rst_n_o | output | 1 | System reset, active low |
| sec_fail_n_o | output | 1 | Second-rail failure flag, active low |
| bus_abort_o | output | 1 | One-cycle strobe to abort serial activity |

## Verification
Two functions can meet in one cycle: the watchdog expiry, and a restart from a bus start condition. The bench enables the watchdog and places the data-line fall so that the synchronized start reaches the counter in exactly the cycle in which the count would hit its limit. It then checks that the reset stays high past the original expiry point. It also checks that the next expiry comes a full timeout after the kick. A second case brings on a brownout while the watchdog is enabled. In that case the count stays frozen, and the expiry is timed from the release that follows the power-up delay.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Digitized comparator decisions
  typedef struct packed {
    logic vmin;
    logic pri;
    logic sec;
  } rail_sense_t;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/supv_start_detect.sv
module supv_start_detect #(
  parameter int STAGES = supv_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o
);
  // index STAGES-1 is the synchronized value, index STAGES the previous one
  logic [STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign start_o = scl_sh[STAGES-1] & scl_sh[STAGES] & sda_sh[STAGES] & ~sda_sh[STAGES-1];

  a_r7_start_single : assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int DLY = 7_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_i,
  output logic done_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt_q;

  // Saturating up-counter, cleared on every bad sample
  always_ff @(posedge clk) begin
    if (rst || !ok_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  a_r3_dip_clears : assert property (@(posedge clk) disable iff (rst)
    !ok_i |=> !done_o);
  a_r2_done_after_good : assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(ok_i));
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int TMO   = 7_500_000,
  parameter int PULSE = 7_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic kick_i,
  output logic pulse_o
);
  localparam int TW = $clog2(TMO);
  localparam int PW = $clog2(PULSE + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO - 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE);

  logic [TW-1:0] cnt_q;
  logic [PW-1:0] pls_q;
  logic          expire;

  // A kick in the expiry cycle wins
  assign expire = run_i & ~kick_i & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || kick_i || expire) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)              pls_q <= '0;
    else if (expire)      pls_q <= PLEN;
    else if (pls_q != '0) pls_q <= pls_q - 1'b1;
  end

  assign pulse_o = (pls_q != '0);

  a_r8_idle_cleared : assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
  a_r6_expire_pulse : assert property (@(posedge clk) disable iff (rst)
    expire |=> pulse_o);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import supv_pkg::*;
#(
  parameter int PU_DLY    = 7_500_000,
  parameter int WD_TMO    = 7_500_000,
  parameter int RST_PULSE = 7_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic vmin_ok_i,
  input  logic pri_ok_i,
  input  logic sec_ok_i,
  input  logic wdog_en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sys_rst_n_o,
  output logic sec_fail_n_o,
  output logic bus_abort_o
);
  rail_sense_t sense;
  logic pwr_good, dly_done, wd_pulse, bus_start;
  logic pg_q, rst_n_q, fail_n_q, abort_q;

  assign sense    = '{vmin: vmin_ok_i, pri: pri_ok_i, sec: sec_ok_i};
  assign pwr_good = sense.vmin & sense.pri;

  supv_hold_timer #(.DLY(PU_DLY)) u_hold (
    .clk(clk), .rst(rst), .ok_i(pwr_good), .done_o(dly_done));

  supv_start_detect #(.STAGES(SYNC_STAGES)) u_start (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .start_o(bus_start));

  supv_wdog #(.TMO(WD_TMO), .PULSE(RST_PULSE)) u_wdog (
    .clk(clk), .rst(rst), .run_i(wdog_en_i & rst_n_q),
    .kick_i(bus_start), .pulse_o(wd_pulse));

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q     <= 1'b0;
      rst_n_q  <= 1'b0;
      fail_n_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      pg_q     <= pwr_good;
      rst_n_q  <= pwr_good & dly_done & ~wd_pulse;
      fail_n_q <= sense.sec & sense.vmin;
      abort_q  <= pg_q & ~pwr_good;
    end
  end

  assign sys_rst_n_o  = rst_n_q;
  assign sec_fail_n_o = fail_n_q;
  assign bus_abort_o  = abort_q;

  a_r1_low_supply_reset : assert property (@(posedge clk) disable iff (rst)
    (!vmin_ok_i || !pri_ok_i) |=> !sys_rst_n_o);
  a_r4_fail_release : assert property (@(posedge clk) disable iff (rst)
    (sec_ok_i && vmin_ok_i) |=> sec_fail_n_o);
  a_r4_fail_assert : assert property (@(posedge clk) disable iff (rst)
    !sec_ok_i |=> !sec_fail_n_o);
  a_r5_abort_single : assert property (@(posedge clk) disable iff (rst)
    bus_abort_o |=> !bus_abort_o);
  a_r5_abort_in_reset : assert property (@(posedge clk) disable iff (rst)
    bus_abort_o |-> !sys_rst_n_o);
  a_r9_reset_state : assert property (@(posedge clk)
    $past(rst) |-> (!sys_rst_n_o && !sec_fail_n_o && !bus_abort_o));
endmodule

// File: tb/test_rail_supervisor.sv
module test_rail_supervisor;
  localparam int TPU = 20;
  localparam int TWD = 40;
  localparam int TRP = 12;
  localparam int NV  = 11;

  // [13] vmin [12] pri [11] sec [10:3] edges to hold [2] exp rst_n [1] exp fail_n [0] exp abort
  localparam logic [13:0] VEC [NV] = '{
    {3'b110, 8'd1,      3'b100},
    {3'b111, 8'd1,      3'b110},
    {3'b101, 8'd1,      3'b011},
    {3'b111, 8'd5,      3'b010},
    {3'b100, 8'd1,      3'b001},
    {3'b111, 8'(TPU),   3'b010},
    {3'b111, 8'd1,      3'b110},
    {3'b011, 8'd1,      3'b001},
    {3'b000, 8'd3,      3'b000},
    {3'b111, 8'(TPU),   3'b010},
    {3'b111, 8'd1,      3'b110}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic vmin = 1'b0, pri = 1'b1, sec = 1'b1, wen = 1'b0, scl = 1'b1, sda = 1'b1;
  logic rst_n, fail_n, abort;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rail_supervisor #(.PU_DLY(TPU), .WD_TMO(TWD), .RST_PULSE(TRP)) i_rail_supervisor (
    .clk(clk), .rst(rst), .vmin_ok_i(vmin), .pri_ok_i(pri), .sec_ok_i(sec),
    .wdog_en_i(wen), .scl_i(scl), .sda_i(sda),
    .sys_rst_n_o(rst_n), .sec_fail_n_o(fail_n), .bus_abort_o(abort));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(2);
    chk("R9 reset rst_n", rst_n, 1'b0);
    chk("R9 reset fail_n", fail_n, 1'b0);
    chk("R9 reset abort", abort, 1'b0);
    rst = 1'b0;
    step(3);
    chk("R1 supply invalid rst_n", rst_n, 1'b0);
    chk("R4 supply invalid fail_n", fail_n, 1'b0);
    // power-up release delay
    vmin = 1'b1;
    step(TPU);
    chk("R2 still held at delay end", rst_n, 1'b0);
    chk("R4 fail released", fail_n, 1'b1);
    step(1);
    chk("R2 released after delay", rst_n, 1'b1);

    // table walk: R1 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      {vmin, pri, sec} = VEC[i][13:11];
      step(int'(VEC[i][10:3]));
      chk($sformatf("table R1 R3 rst_n entry %0d", i), rst_n, VEC[i][2]);
      chk($sformatf("table R4 fail_n entry %0d", i), fail_n, VEC[i][1]);
      chk($sformatf("table R5 abort entry %0d", i), abort, VEC[i][0]);
    end

    // R6: expiry and pulse width
    wen = 1'b1;
    step(TWD);
    chk("R6 high before expiry", rst_n, 1'b1);
    step(1);
    chk("R6 pulse start", rst_n, 1'b0);
    chk("R5 no abort on watchdog reset", abort, 1'b0);
    step(TRP - 1);
    chk("R6 pulse last cycle", rst_n, 1'b0);
    step(1);
    chk("R6 pulse end", rst_n, 1'b1);
    wen = 1'b0;

    // R7: periodic kicks keep reset released
    step(2);
    wen = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(15);
      sda = 1'b0;
      step(2);
      scl = 1'b0;
      step(1);
      sda = 1'b1;
      step(1);
      scl = 1'b1;
      step(1);
      chk($sformatf("R7 kick %0d keeps release", k), rst_n, 1'b1);
    end
    wen = 1'b0;

    // R7: data edges while clock low are not starts
    step(2);
    wen = 1'b1;
    scl = 1'b0;
    for (int j = 0; j < TWD; j++) begin
      @(posedge clk);
      @(negedge clk);
      sda = ~sda;
    end
    chk("R7 scl-low toggles before expiry", rst_n, 1'b1);
    step(1);
    chk("R7 scl-low toggles do not kick", rst_n, 1'b0);
    sda = 1'b1;
    step(TRP);
    chk("R6 pulse over", rst_n, 1'b1);
    wen = 1'b0;
    scl = 1'b1;

    // R7: start in the expiry cycle cancels expiry
    step(3);
    wen = 1'b1;
    step(TWD - 3);
    sda = 1'b0;
    step(4);
    chk("R7 start beats expiry", rst_n, 1'b1);
    scl = 1'b0;
    step(1);
    sda = 1'b1;
    step(1);
    scl = 1'b1;
    step(TWD - 3);
    chk("R7 full timeout after kick", rst_n, 1'b1);
    step(1);
    chk("R7 expiry after kick", rst_n, 1'b0);
    step(TRP);
    wen = 1'b0;
    chk("R6 released after pulse", rst_n, 1'b1);

    // R8: watchdog frozen during brownout
    step(1);
    wen = 1'b1;
    pri = 1'b0;
    step(1);
    chk("R5 abort on brownout", abort, 1'b1);
    step(TWD + 10);
    chk("R8 held in brownout", rst_n, 1'b0);
    pri = 1'b1;
    step(TPU);
    chk("R8 no pulse stretch", rst_n, 1'b0);
    step(1);
    chk("R2 release after brownout", rst_n, 1'b1);
    step(TWD);
    chk("R8 count starts at release", rst_n, 1'b1);
    step(1);
    chk("R8 expiry timed from release", rst_n, 1'b0);
    wen = 1'b0;
    step(TRP + 2);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule